// File: doc/BRIEF.md
# Pattern-Plane Program Sequencer

This block runs a small stored program over three binary pattern planes of 192 cells each: a source plane that the cell array normally reads, a result plane that the cell array writes, and a spare plane that holds a pattern between steps. Each program word is 12 bits and belongs to one of two kinds. A transfer word moves whole planes in one clock or rotates them through the serial pixel port. A compute word sets up the cell array, waits for the array to finish, and writes the array's result into the result plane.

The program store has 32 slots, and each slot has its own valid flag. A slot whose flag is clear costs no cycles. The sequencer can run a single word and then stop, make one pass over the program, or repeat the program for as long as `run` stays high. Software fills the store while `run` is low. Scanning and display equipment are not part of the block. The serial port carries one bit per clock while `ser_active` is high.

Top module: `pattern_sequencer`

## Requirements
- R1: After reset, `busy`, `arr_start` and `ser_active` are low and all three planes hold zeros.
- R2: A transfer word with bit 0 set rotates the source plane through the serial port. The rotation takes exactly 192 clocks and follows a one-clock transfer step, so the word keeps `busy` high for 193 clocks. `in_tap` presents cell 0 first. When `ser_load` is high, the k-th bit sampled on `ser_in` becomes cell k; otherwise the plane returns unchanged.
- R3: A transfer word with bit 1 set presents the result plane on `disp_bit` in the same rotating way, cell 0 first. The plane is unchanged afterwards, so a second display gives the same stream.
- R4: In a transfer word, bit 2 loads the source plane with the complement of the result plane and bit 3 copies the result plane into the spare plane. Both happen in the word's first clock and both read the result plane as it stood before that clock. Any serial rotation in the same word follows them.
- R5: A compute word has bit 11 set. It drives `arr_func` from bits 7:0 and `arr_border` from bit 10, and raises `arr_start` for exactly one clock. `arr_a0` is the source plane, or the spare plane when bit 8 is set. `arr_g` is all zeros unless bit 9 is set; it then carries the spare plane, or the source plane when bit 8 is also set.
- R6: A compute word holds until `arr_done` is high. The result plane then takes `arr_result` in that clock. The result plane changes only by this capture or by a display rotation.
- R7: Slots with a clear valid flag are skipped without spending any clock. A pass of k valid one-clock transfer words keeps `busy` high for exactly k clocks, wherever the gaps fall.
- R8: With `single` high, each assertion of `run` executes only the next valid slot at or after the stored position, then waits for `run` to go low. A later assertion continues from the following slot.
- R9: With `loop_en` high, the program restarts at its first valid slot after the last one, for as long as `run` stays high. Lowering `run` stops the sequencer after the current word.
- R10: A program write takes effect only while `run` is low and the sequencer is idle. Writes at other times are ignored.
- R11: A pass that ends without looping returns the stored position to slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run | input | 1 | Start and keep executing |
| single | input | 1 | Execute one word per run assertion |
| loop_en | input | 1 | Repeat the program without end |
| prog_we | input | 1 | Program slot write enable |
| prog_addr | input | 5 | Program slot index |
| prog_word | input | 12 | Program word to store |
| prog_valid | input | 1 | Valid flag written with the word |
| ser_load | input | 1 | Replace recirculated source bits with ser_in |
| ser_in | input | 1 | Serial bit entering the source plane |
| in_tap | output | 1 | Source plane cell 0 during rotation |
| disp_bit | output | 1 | Result plane cell 0 during rotation |
| ser_active | output | 1 | A serial rotation clock is in progress |
| busy | output | 1 | A word is executing |
| arr_a0 | output | 192 | Plane presented as cell inputs |
| arr_g | output | 192 | Plane presented to the neighbour gates |
| arr_border | output | 1 | Value for the edge connections |
| arr_func | output | 8 | Cell function bits |
| arr_start | output | 1 | One-clock start for the cell array |
| arr_done | input | 1 | Cell array result is settled |
| arr_result | input | 192 | Settled cell array output |

## Verification
The source-plane load and the spare-plane copy can fall in the same clock, and both read the result plane. The bench provokes this with one transfer word that sets both bits together with a display rotation. A following compute word with routing swapped and the gate enabled must then show the old result on `arr_a0` and its complement on `arr_g`. A program write issued while a looping run is active must have no effect: a later single step has to execute the original word.

// File: rtl/pseq_pkg.sv
// Shared word layout and controller states for the pattern-plane sequencer.
// Assumes a 12-bit program word; bit positions below are decoded by the controller.
package pseq_pkg;
    localparam int IW       = 12;
    localparam int FW       = 8;
    localparam int B_TYPE   = 11;  // 1 = compute word, 0 = transfer word
    localparam int B_RECIRC = 0;   // transfer: rotate source plane via serial port
    localparam int B_SHOW   = 1;   // transfer: rotate result plane onto disp_bit
    localparam int B_CPL    = 2;   // transfer: source <= ~result
    localparam int B_SAVE   = 3;   // transfer: spare <= result
    localparam int B_SWAP   = 8;   // compute: exchange source and spare roles
    localparam int B_GATE   = 9;   // compute: feed a plane to the gates
    localparam int B_EDGE   = 10;  // compute: edge connections at 1

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XFER,
        ST_SHIFT,
        ST_PSTART,
        ST_PWAIT,
        ST_HOLD
    } seq_state_t;
endpackage

// File: rtl/pseq_store.sv
// Program store: SLOTS words with a valid flag each, plus two lowest-valid-slot
// searches (one from a start index, one from slot 0) used for zero-cost skipping.
// Assumes writes are presented only by software while the sequencer is stopped.
module pseq_store #(
    parameter int SLOTS = 32,
    parameter int IW    = 12,
    localparam int SW   = $clog2(SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          idle,
    input  logic          wr_en,
    input  logic [SW-1:0] wr_addr,
    input  logic [IW-1:0] wr_word,
    input  logic          wr_valid,
    input  logic [SW:0]   q_from,
    output logic          f_hit,
    output logic [SW-1:0] f_idx,
    output logic [IW-1:0] f_word,
    output logic          z_hit,
    output logic [SW-1:0] z_idx,
    output logic [IW-1:0] z_word
);
    logic [IW-1:0]    mem_q [SLOTS];
    logic [SLOTS-1:0] valid_q;

    // Accept program writes only when stopped and idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            for (int i = 0; i < SLOTS; i++) mem_q[i] <= '0;
        end else if (wr_en && !run && idle) begin
            mem_q[wr_addr]   <= wr_word;
            valid_q[wr_addr] <= wr_valid;
        end
    end

    // Lowest valid slot at or above q_from, and lowest valid slot overall.
    always_comb begin
        f_hit = 1'b0;
        f_idx = '0;
        z_hit = 1'b0;
        z_idx = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (valid_q[i]) begin
                z_hit = 1'b1;
                z_idx = SW'(i);
                if (i >= int'(q_from)) begin
                    f_hit = 1'b1;
                    f_idx = SW'(i);
                end
            end
        end
    end

    assign f_word = mem_q[f_idx];
    assign z_word = mem_q[z_idx];

    AST_PROG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> $stable(valid_q)); // R10
endmodule

// File: rtl/pseq_planes.sv
// The three pattern planes: source, result and spare. Handles one-clock parallel
// transfers, serial rotation (cell 0 leaves first), result capture and the
// routing of planes onto the cell-array inputs. Assumes the controller never
// requests capture and display rotation in the same clock.
module pseq_planes #(
    parameter int N = 192
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         do_cpl,
    input  logic         do_save,
    input  logic         sh_in,
    input  logic         sh_out,
    input  logic         cap,
    input  logic         swap,
    input  logic         gate,
    input  logic         ser_load,
    input  logic         ser_in,
    input  logic [N-1:0] result,
    output logic [N-1:0] a0,
    output logic [N-1:0] g,
    output logic         in_tap,
    output logic         disp_bit
);
    logic [N-1:0] in_q, out_q, aux_q;
    logic         in_new;

    assign in_new = ser_load ? ser_in : in_q[0];

    // Source plane: complement load or serial rotation.
    always_ff @(posedge clk) begin
        if (!rst_n)       in_q <= '0;
        else if (do_cpl)  in_q <= ~out_q;
        else if (sh_in)   in_q <= {in_new, in_q[N-1:1]};
    end

    // Result plane: capture from the array or display rotation.
    always_ff @(posedge clk) begin
        if (!rst_n)       out_q <= '0;
        else if (cap)     out_q <= result;
        else if (sh_out)  out_q <= {out_q[0], out_q[N-1:1]};
    end

    // Spare plane: parallel copy of the result plane.
    always_ff @(posedge clk) begin
        if (!rst_n)       aux_q <= '0;
        else if (do_save) aux_q <= out_q;
    end

    // Routing of planes toward the cell array.
    always_comb begin
        a0 = swap ? aux_q : in_q;
        g  = gate ? (swap ? in_q : aux_q) : '0;
    end

    assign in_tap   = in_q[0];
    assign disp_bit = out_q[0];

    AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap && !sh_out) |=> $stable(out_q)); // R6
    AST_AUX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !do_save |=> $stable(aux_q)); // R4
    AST_IN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!do_cpl && !sh_in) |=> $stable(in_q)); // R2
endmodule

// File: rtl/pseq_ctrl.sv
// Sequencer controller: fetches the next valid slot, decodes transfer and
// compute words, counts serial rotations, runs the start/done handshake and
// applies single, pass and loop execution. Assumes arr_done is only meaningful
// after arr_start.
module pseq_ctrl
    import pseq_pkg::*;
#(
    parameter int N     = 192,
    parameter int SLOTS = 32,
    localparam int SW   = $clog2(SLOTS),
    localparam int CW   = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          single,
    input  logic          loop_en,
    input  logic          f_hit,
    input  logic [SW-1:0] f_idx,
    input  logic [IW-1:0] f_word,
    input  logic          z_hit,
    input  logic [SW-1:0] z_idx,
    input  logic [IW-1:0] z_word,
    input  logic          arr_done,
    output logic [SW:0]   q_from,
    output logic          idle,
    output logic          do_cpl,
    output logic          do_save,
    output logic          sh_in,
    output logic          sh_out,
    output logic          cap,
    output logic          swap,
    output logic          gate,
    output logic          arr_start,
    output logic          arr_border,
    output logic [FW-1:0] arr_func,
    output logic          ser_active,
    output logic          busy
);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    seq_state_t    state, n_state;
    logic [IW-1:0] ir, n_ir;
    logic [SW-1:0] cur, n_cur, pc, n_pc;
    logic [CW-1:0] cnt, n_cnt;
    logic          take_f, take_z, ending, proc_ph;

    // Where the next-slot search begins.
    assign q_from = (state == ST_IDLE) ? {1'b0, pc} : ({1'b0, cur} + (SW + 1)'(1));

    // Next-state, fetch and end-of-word decisions.
    always_comb begin
        n_state = state;
        n_ir    = ir;
        n_cur   = cur;
        n_pc    = pc;
        n_cnt   = cnt;
        take_f  = 1'b0;
        take_z  = 1'b0;
        ending  = 1'b0;
        case (state)
            ST_IDLE: begin
                if (run) begin
                    if (f_hit)      take_f = 1'b1;
                    else if (z_hit) take_z = 1'b1;
                end
            end
            ST_XFER: begin
                if (ir[B_RECIRC] || ir[B_SHOW]) n_state = ST_SHIFT;
                else                            ending  = 1'b1;
            end
            ST_SHIFT: begin
                if (cnt == LAST) ending = 1'b1;
                else             n_cnt  = cnt + CW'(1);
            end
            ST_PSTART: n_state = ST_PWAIT;
            ST_PWAIT:  if (arr_done) ending = 1'b1;
            ST_HOLD:   if (!run) n_state = ST_IDLE;
            default:   n_state = ST_IDLE;
        endcase
        if (ending) begin
            if (single) begin
                n_pc    = cur + SW'(1);
                n_state = ST_HOLD;
            end else if (!run) begin
                n_pc    = cur + SW'(1);
                n_state = ST_IDLE;
            end else if (f_hit) begin
                take_f = 1'b1;
            end else begin
                n_pc = '0;
                if (loop_en && z_hit) take_z  = 1'b1;
                else                  n_state = ST_HOLD;
            end
        end
        if (take_f) begin
            n_cur   = f_idx;
            n_ir    = f_word;
            n_cnt   = '0;
            n_state = f_word[B_TYPE] ? ST_PSTART : ST_XFER;
        end else if (take_z) begin
            n_cur   = z_idx;
            n_ir    = z_word;
            n_cnt   = '0;
            n_state = z_word[B_TYPE] ? ST_PSTART : ST_XFER;
        end
    end

    // Controller registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            ir    <= '0;
            cur   <= '0;
            pc    <= '0;
            cnt   <= '0;
        end else begin
            state <= n_state;
            ir    <= n_ir;
            cur   <= n_cur;
            pc    <= n_pc;
            cnt   <= n_cnt;
        end
    end

    // Decoded controls toward the planes and the array.
    always_comb begin
        proc_ph    = (state == ST_PSTART || state == ST_PWAIT) && ir[B_TYPE];
        idle       = (state == ST_IDLE);
        busy       = !(state == ST_IDLE || state == ST_HOLD);
        do_cpl     = (state == ST_XFER) && ir[B_CPL];
        do_save    = (state == ST_XFER) && ir[B_SAVE];
        sh_in      = (state == ST_SHIFT) && ir[B_RECIRC];
        sh_out     = (state == ST_SHIFT) && ir[B_SHOW];
        ser_active = (state == ST_SHIFT);
        cap        = (state == ST_PWAIT) && arr_done;
        swap       = ir[B_SWAP];
        gate       = ir[B_GATE];
        arr_start  = (state == ST_PSTART);
        arr_border = proc_ph && ir[B_EDGE];
        arr_func   = proc_ph ? ir[FW-1:0] : '0;
    end

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        arr_start |=> !arr_start); // R5
    AST_WAIT_FOR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PWAIT && !arr_done) |=> (state == ST_PWAIT)); // R6
    AST_SHIFT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        ser_active |-> (cnt <= LAST)); // R2
    AST_IDLE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !run) |=> !busy); // R8
endmodule

// File: rtl/pattern_sequencer.sv
// Top of the pattern-plane sequencer: joins the program store, the controller
// and the plane storage. Assumes the cell array holds arr_result stable while
// arr_done is high.
module pattern_sequencer #(
    parameter int N     = 192,
    parameter int SLOTS = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run,
    input  logic                     single,
    input  logic                     loop_en,
    input  logic                     prog_we,
    input  logic [$clog2(SLOTS)-1:0] prog_addr,
    input  logic [11:0]              prog_word,
    input  logic                     prog_valid,
    input  logic                     ser_load,
    input  logic                     ser_in,
    output logic                     in_tap,
    output logic                     disp_bit,
    output logic                     ser_active,
    output logic                     busy,
    output logic [N-1:0]             arr_a0,
    output logic [N-1:0]             arr_g,
    output logic                     arr_border,
    output logic [7:0]               arr_func,
    output logic                     arr_start,
    input  logic                     arr_done,
    input  logic [N-1:0]             arr_result
);
    import pseq_pkg::*;
    localparam int SW = $clog2(SLOTS);

    logic          idle, f_hit, z_hit;
    logic [SW:0]   q_from;
    logic [SW-1:0] f_idx, z_idx;
    logic [IW-1:0] f_word, z_word;
    logic          do_cpl, do_save, sh_in, sh_out, cap, swap, gate;

    pseq_store #(.SLOTS(SLOTS), .IW(IW)) store_i (
        .clk(clk), .rst_n(rst_n), .run(run), .idle(idle),
        .wr_en(prog_we), .wr_addr(prog_addr), .wr_word(prog_word),
        .wr_valid(prog_valid), .q_from(q_from),
        .f_hit(f_hit), .f_idx(f_idx), .f_word(f_word),
        .z_hit(z_hit), .z_idx(z_idx), .z_word(z_word)
    );

    pseq_ctrl #(.N(N), .SLOTS(SLOTS)) ctrl_i (
        .clk(clk), .rst_n(rst_n), .run(run), .single(single), .loop_en(loop_en),
        .f_hit(f_hit), .f_idx(f_idx), .f_word(f_word),
        .z_hit(z_hit), .z_idx(z_idx), .z_word(z_word),
        .arr_done(arr_done), .q_from(q_from), .idle(idle),
        .do_cpl(do_cpl), .do_save(do_save), .sh_in(sh_in), .sh_out(sh_out),
        .cap(cap), .swap(swap), .gate(gate),
        .arr_start(arr_start), .arr_border(arr_border), .arr_func(arr_func),
        .ser_active(ser_active), .busy(busy)
    );

    pseq_planes #(.N(N)) planes_i (
        .clk(clk), .rst_n(rst_n),
        .do_cpl(do_cpl), .do_save(do_save), .sh_in(sh_in), .sh_out(sh_out),
        .cap(cap), .swap(swap), .gate(gate),
        .ser_load(ser_load), .ser_in(ser_in), .result(arr_result),
        .a0(arr_a0), .g(arr_g), .in_tap(in_tap), .disp_bit(disp_bit)
    );
endmodule

// File: tb/pattern_sequencer_tb.sv
// Bench for pattern_sequencer: models the cell array and serial port at the
// falling edge, drives control from tasks, and checks against plane models.
module pattern_sequencer_tb_top;
    localparam int N = 192;
    localparam int SLOTS = 32;

    logic clk = 0, rst_n = 0, run = 0, single = 0, loop_en = 0;
    logic prog_we = 0, prog_valid = 0, ser_load = 0, ser_in = 0;
    logic [4:0] prog_addr = '0;
    logic [11:0] prog_word = '0;
    logic in_tap, disp_bit, ser_active, busy, arr_border, arr_start;
    logic arr_done = 0;
    logic [N-1:0] arr_a0, arr_g;
    logic [N-1:0] arr_result = '0;
    logic [7:0] arr_func;

    pattern_sequencer #(.N(N), .SLOTS(SLOTS)) dut_i (
        .clk(clk), .rst_n(rst_n), .run(run), .single(single), .loop_en(loop_en),
        .prog_we(prog_we), .prog_addr(prog_addr), .prog_word(prog_word),
        .prog_valid(prog_valid), .ser_load(ser_load), .ser_in(ser_in),
        .in_tap(in_tap), .disp_bit(disp_bit), .ser_active(ser_active), .busy(busy),
        .arr_a0(arr_a0), .arr_g(arr_g), .arr_border(arr_border), .arr_func(arr_func),
        .arr_start(arr_start), .arr_done(arr_done), .arr_result(arr_result)
    );

    always #4 clk = ~clk;  // 125 MHz

    int n_chk = 0, n_err = 0;
    int sk = 0, shcnt = 0, busy_cycles = 0, starts = 0, dly = 0;
    bit pend = 0;
    logic [N-1:0] ser_src = '0, tap_cap = '0, disp_cap = '0;
    logic [N-1:0] obs_a0 = '0, obs_g = '0;
    logic obs_border = 0;
    logic [7:0] obs_func = '0;
    logic [7:0] flog [64];

    function automatic logic [N-1:0] res_of(logic [N-1:0] a, logic [N-1:0] gg,
                                            logic b, logic [7:0] f);
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = a[i] ^ gg[i] ^ b ^ f[i % 8];
        return r;
    endfunction

    function automatic logic [N-1:0] rnd_plane();
        logic [N-1:0] r;
        for (int i = 0; i < N; i++) r[i] = 1'($urandom % 2);
        return r;
    endfunction

    function automatic logic [11:0] ld(bit rc, bit sh, bit cp, bit sv);
        return {8'h00, sv, cp, sh, rc};
    endfunction

    function automatic logic [11:0] pr(bit sw, bit gt, bit ed, logic [7:0] f);
        return {1'b1, ed, gt, sw, f};
    endfunction

    // Array and serial-port model, active on the falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            arr_done = 1'b0;
            if (pend) begin
                if (dly == 0) begin
                    arr_done   = 1'b1;
                    arr_result = res_of(obs_a0, obs_g, obs_border, obs_func);
                    pend       = 1'b0;
                end else dly--;
            end
            if (arr_start) begin
                obs_a0 = arr_a0; obs_g = arr_g;
                obs_border = arr_border; obs_func = arr_func;
                flog[starts % 64] = arr_func;
                starts++;
                pend = 1'b1;
                dly  = int'($urandom % 4);
            end
            if (ser_active) begin
                tap_cap[sk]  = in_tap;
                disp_cap[sk] = disp_bit;
                ser_in       = ser_src[sk];
                sk++;
                shcnt++;
            end else sk = 0;
            if (busy) busy_cycles++;
        end
    end

    task automatic tick(int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic chk(bit ok, string req, string what, logic [N-1:0] act, logic [N-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic put(int a, logic [11:0] w, bit v);
        prog_we = 1; prog_addr = 5'(a); prog_word = w; prog_valid = v;
        tick(1);
        prog_we = 0;
    endtask

    task automatic clear_all();
        for (int i = 0; i < SLOTS; i++) put(i, 12'h000, 1'b0);
    endtask

    task automatic go(bit sgl);
        single = sgl; loop_en = 0; busy_cycles = 0; shcnt = 0;
        run = 1;
        while (!busy) tick(1);
        while (busy) tick(1);
        run = 0;
        tick(2);
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
        report();
        $finish;
    end

    initial begin
        logic [N-1:0] ein, eout, eaux, p1;
        logic [7:0] f1;
        logic b1;
        int s0;
        bit ok;
        logic [7:0] cyc [3];
        void'($urandom(32'd4711));
        tick(3);
        rst_n = 1;
        tick(1);

        // R1: quiet after reset
        chk(!busy && !arr_start && !ser_active, "R1", "outputs after reset",
            N'({busy, arr_start, ser_active}), '0);

        // R2: serial load of the source plane
        clear_all();
        put(0, ld(1, 0, 0, 0), 1);
        p1 = rnd_plane(); ser_src = p1; ser_load = 1;
        go(0);
        ser_load = 0;
        chk(shcnt == N, "R2", "rotation length", N'(shcnt), N'(N));
        chk(busy_cycles == N + 1, "R2", "busy cycles of rotating word", N'(busy_cycles), N'(N + 1));
        ein = p1;

        // R2 recirculation, R1 result plane zero after reset
        put(0, ld(1, 1, 0, 0), 1);
        go(0);
        chk(tap_cap == ein, "R2", "source stream", tap_cap, ein);
        chk(disp_cap == '0, "R1", "result plane after reset", disp_cap, '0);

        // R5 / R6: plain compute word
        f1 = 8'($urandom); b1 = 1'($urandom % 2);
        put(0, pr(0, 0, b1, f1), 1);
        go(0);
        chk(obs_a0 == ein, "R5", "a0 is source", obs_a0, ein);
        chk(obs_g == '0, "R5", "gate idle", obs_g, '0);
        chk({obs_border, obs_func} == {b1, f1}, "R5", "border and func",
            N'({obs_border, obs_func}), N'({b1, f1}));
        eout = res_of(ein, '0, b1, f1);
        put(0, ld(1, 1, 0, 0), 1);
        go(0);
        chk(disp_cap == eout, "R6", "captured result", disp_cap, eout);
        chk(tap_cap == ein, "R2", "source unchanged by recirculation", tap_cap, ein);

        // R3: display is non-destructive
        put(0, ld(0, 1, 0, 0), 1);
        go(0);
        chk(disp_cap == eout, "R3", "second display", disp_cap, eout);

        // R4: complement load and spare copy in one clock, with display
        put(0, ld(0, 1, 1, 1), 1);
        go(0);
        chk(disp_cap == eout, "R3", "display after transfers", disp_cap, eout);
        ein = ~eout; eaux = eout;
        f1 = 8'($urandom); b1 = 1'($urandom % 2);
        put(0, pr(1, 1, b1, f1), 1);
        go(0);
        chk(obs_a0 == eaux, "R4", "swapped a0 is spare", obs_a0, eaux);
        chk(obs_g == ein, "R5", "swapped gate is source", obs_g, ein);
        eout = res_of(eaux, ein, b1, f1);
        f1 = 8'($urandom);
        put(0, pr(0, 1, 0, f1), 1);
        go(0);
        chk(obs_a0 == ein, "R5", "unswapped a0", obs_a0, ein);
        chk(obs_g == eaux, "R5", "gate is spare", obs_g, eaux);
        eout = res_of(ein, eaux, 1'b0, f1);
        // R4 ordering: complement then recirculate in one word
        put(0, ld(1, 0, 1, 0), 1);
        go(0);
        chk(tap_cap == ~eout, "R4", "complement precedes rotation", tap_cap, ~eout);
        ein = ~eout;

        // R7: gaps cost nothing
        clear_all();
        put(3, ld(0, 0, 0, 1), 1);
        put(9, ld(0, 0, 0, 1), 1);
        put(20, ld(0, 0, 0, 1), 1);
        go(0);
        chk(busy_cycles == 3, "R7", "busy cycles for three words", N'(busy_cycles), N'(3));

        // R8: single step walks valid slots
        put(3, pr(0, 0, 0, 8'h11), 1);
        put(9, pr(0, 0, 0, 8'h22), 1);
        put(20, pr(0, 0, 0, 8'h33), 1);
        go(1);
        chk(flog[(starts - 1) % 64] == 8'h11, "R8", "first step", N'(flog[(starts - 1) % 64]), N'(8'h11));
        go(1);
        chk(flog[(starts - 1) % 64] == 8'h22, "R8", "second step", N'(flog[(starts - 1) % 64]), N'(8'h22));
        s0 = starts;
        go(0);
        chk(starts - s0 == 1 && flog[(starts - 1) % 64] == 8'h33, "R8", "pass resumes at slot 20",
            N'(starts - s0), N'(1));
        go(1);
        chk(flog[(starts - 1) % 64] == 8'h11, "R11", "position back at start", N'(flog[(starts - 1) % 64]), N'(8'h11));

        // R9: looping, with a write attempt during the run (R10)
        s0 = starts;
        single = 0; loop_en = 1; run = 1;
        while (starts < s0 + 7) tick(1);
        prog_we = 1; prog_addr = 5'd3; prog_word = pr(0, 0, 0, 8'h77); prog_valid = 1;
        tick(1);
        prog_we = 0;
        run = 0;
        while (busy) tick(1);
        tick(2);
        loop_en = 0;
        cyc[0] = 8'h22; cyc[1] = 8'h33; cyc[2] = 8'h11;
        ok = 1;
        for (int k = 0; k < 7; k++) if (flog[(s0 + k) % 64] != cyc[k % 3]) ok = 0;
        chk(ok, "R9", "loop order", N'(flog[(s0 + 3) % 64]), N'(cyc[0]));
        chk(!busy, "R9", "stops after run drops", N'(busy), '0);
        go(0);
        go(1);
        chk(flog[(starts - 1) % 64] == 8'h11, "R10", "write during run ignored", N'(flog[(starts - 1) % 64]), N'(8'h11));

        report();
        $finish;
    end
endmodule